// File: doc/BRIEF.md
# Sub-Sleep Power Mode Sequencer

This block decides whether a sleep request from the CPU puts a small microcontroller into its sub-sleep mode. While the system stays there, it drives the CPU halt line and per-module clock-enable and reset lines. In sub-sleep only the two watchdog timers keep their clocks. Four peripheral groups lose their state and are held in reset: serial, converter, CAN and motor PWM. Every other module keeps its state with its clock stopped.

While asleep, the block checks each wake-up source against its enable and mask state. A qualified wake-up leads to a one-cycle exception-start pulse. Two pins take priority over this. The reset pin moves the system to a reset mode. The standby pin, when driven low, forces hardware standby from any mode. The block leaves hardware standby only through the reset mode. A sleep request made under any other setting of the three control bits is refused and flagged.

The mode is reported on a three-bit output with these codes: 0 run, 1 sub-sleep, 2 wake, 3 hardware standby, 4 reset.

Top module: `subsleep_ctrl`

## Requirements
- R1: In run mode (0), a `sleep_strobe` with `sel_sw_standby`=0, `sel_low_speed`=1 and `sel_wdog_prescale`=1 makes `mode` equal 1 one clock later.
- R2: In run mode, a `sleep_strobe` with any other setting of the three select bits leaves `mode` at 0 and raises `sleep_nack` for exactly the one cycle after the strobe.
- R3: In sub-sleep, `cpu_halt` is 1 and `mod_clk_en` equals `KEEP_MASK` (default 8'h03, bits 0 and 1 being the watchdogs). In run mode, `cpu_halt` is 0 and `mod_clk_en` is all ones.
- R4: In sub-sleep, `mod_rst` equals `VOLATILE_MASK` (default 8'hF0). In run and wake modes, `mod_rst` is 0.
- R5: In sub-sleep, a request on `irq_req[i]` wakes the block only if `irq_en[i]` is 1. Requests on other lines with their enables set do not substitute for it.
- R6: In sub-sleep, a request on `per_req[i]` wakes the block only if `per_en[i]` is 1 and `cpu_mask` is 0.
- R7: In sub-sleep, `nmi_req` always wakes the block, whatever the enables and the mask.
- R8: A wake-up qualified in a cycle gives `mode`=2 with `exc_start`=1 and `cpu_halt`=0 in the next cycle only. The mode returns to 0 in the cycle after that.
- R9: `standby_pin_n` low in any mode gives `mode`=3 one clock later, with `mod_clk_en`=0, `mod_rst` all ones and `cpu_halt`=1. This overrides the reset pin, wake-ups and sleep requests, and no `sleep_nack` results.
- R10: With `standby_pin_n` high, `reset_pin_n` low gives `mode`=4 one clock later, with `cpu_halt`=1, `mod_rst` all ones and no `exc_start`, even when a wake-up arrives in the same cycle. The first clock with `reset_pin_n` high returns the mode to 0.
- R11: When `standby_pin_n` returns high in hardware standby, the mode becomes 4 for one cycle and then 0.
- R12: After `por_n` is released, `mode` is 0, `cpu_halt`, `exc_start` and `sleep_nack` are 0, and `mod_clk_en` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sleep_strobe | input | 1 | One-cycle pulse for an executed sleep instruction |
| sel_sw_standby | input | 1 | Software-standby select bit |
| sel_low_speed | input | 1 | Low-speed-on bit |
| sel_wdog_prescale | input | 1 | Watchdog-1 prescaler select bit |
| irq_req | input | NUM_IRQ | External interrupt requests |
| irq_en | input | NUM_IRQ | Per-line external interrupt enables |
| per_req | input | NUM_PER | Internal peripheral interrupt requests |
| per_en | input | NUM_PER | Peripheral interrupt-enable bits |
| cpu_mask | input | 1 | CPU mask on peripheral interrupts |
| nmi_req | input | 1 | Non-maskable interrupt request |
| reset_pin_n | input | 1 | Reset pin, active low |
| standby_pin_n | input | 1 | Standby pin, active low |
| cpu_halt | output | 1 | CPU halted |
| mod_clk_en | output | NUM_MOD | Per-module clock enable |
| mod_rst | output | NUM_MOD | Per-module reset |
| mode | output | 3 | Current mode code |
| exc_start | output | 1 | Exception-start pulse |
| sleep_nack | output | 1 | Sleep request refused |

## Verification
Three events can fall in the same cycle: a qualified wake-up, an active reset pin and an active standby pin. The bench drives the non-maskable request together with one pin or with both pins in the same cycle. It then judges which mode code appears one clock later and whether `exc_start` stays low. A second coincidence puts a sleep request and the standby pin together in run mode. The expected result there is hardware standby with no refusal flag.

// File: rtl/subsleep_pkg.sv
package subsleep_pkg;
  typedef enum logic [2:0] {
    MODE_RUN      = 3'd0,
    MODE_SUBSLEEP = 3'd1,
    MODE_WAKE     = 3'd2,
    MODE_HWSTBY   = 3'd3,
    MODE_RESET    = 3'd4
  } pmode_e;

  // The only control-bit setting that permits sub-sleep entry
  function automatic logic entry_combo_ok(input logic ssby, input logic lson, input logic pss);
    return !ssby && lson && pss;
  endfunction

  function automatic logic irq_can_wake(input logic req, input logic en);
    return req && en;
  endfunction

  function automatic logic per_can_wake(input logic req, input logic en, input logic mask);
    return req && en && !mask;
  endfunction
endpackage

// File: rtl/subsleep_entry_qual.sv
module subsleep_entry_qual
  import subsleep_pkg::*;
(
  input  logic sleep_strobe,
  input  logic sel_sw_standby,
  input  logic sel_low_speed,
  input  logic sel_wdog_prescale,
  input  logic in_run,
  input  logic pins_quiet,
  output logic enter_req,
  output logic reject_req
);
  logic combo_ok;
  logic issue;

  always_comb begin
    combo_ok   = entry_combo_ok(sel_sw_standby, sel_low_speed, sel_wdog_prescale);
    issue      = sleep_strobe && in_run && pins_quiet;
    enter_req  = issue && combo_ok;
    reject_req = issue && !combo_ok;
  end
endmodule

// File: rtl/subsleep_wake_qual.sv
module subsleep_wake_qual
  import subsleep_pkg::*;
#(
  parameter int NUM_IRQ = 6,
  parameter int NUM_PER = 8
) (
  input  logic               nmi_req,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_PER-1:0] per_req,
  input  logic [NUM_PER-1:0] per_en,
  input  logic               cpu_mask,
  output logic [NUM_IRQ-1:0] irq_hit,
  output logic [NUM_PER-1:0] per_hit,
  output logic               wake_hit
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    assign irq_hit[i] = irq_can_wake(irq_req[i], irq_en[i]);
  end

  for (genvar j = 0; j < NUM_PER; j++) begin : g_per
    assign per_hit[j] = per_can_wake(per_req[j], per_en[j], cpu_mask);
  end

  assign wake_hit = nmi_req || (|irq_hit) || (|per_hit);
endmodule

// File: rtl/subsleep_mode_fsm.sv
module subsleep_mode_fsm
  import subsleep_pkg::*;
(
  input  logic   clk,
  input  logic   por_n,
  input  logic   enter_req,
  input  logic   reject_req,
  input  logic   wake_hit,
  input  logic   standby_force,
  input  logic   reset_force,
  output pmode_e state,
  output logic   sleep_nack
);
  pmode_e state_nx;

  always_comb begin
    if (standby_force) begin
      state_nx = MODE_HWSTBY;
    end else if (reset_force) begin
      state_nx = MODE_RESET;
    end else begin
      case (state)
        MODE_RUN:      state_nx = enter_req ? MODE_SUBSLEEP : MODE_RUN;
        MODE_SUBSLEEP: state_nx = wake_hit ? MODE_WAKE : MODE_SUBSLEEP;
        MODE_WAKE:     state_nx = MODE_RUN;
        MODE_HWSTBY:   state_nx = MODE_RESET;
        MODE_RESET:    state_nx = MODE_RUN;
        default:       state_nx = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state      <= MODE_RUN;
      sleep_nack <= 1'b0;
    end else begin
      state      <= state_nx;
      sleep_nack <= reject_req;
    end
  end
endmodule

// File: rtl/subsleep_gate.sv
module subsleep_gate
  import subsleep_pkg::*;
#(
  parameter int                NUM_MOD       = 8,
  parameter logic [NUM_MOD-1:0] KEEP_MASK     = 8'h03,
  parameter logic [NUM_MOD-1:0] VOLATILE_MASK = 8'hF0
) (
  input  pmode_e             state,
  output logic [NUM_MOD-1:0] mod_clk_en,
  output logic [NUM_MOD-1:0] mod_rst,
  output logic               cpu_halt,
  output logic               exc_start
);
  logic clocks_full;
  logic rst_full;
  logic asleep;

  assign clocks_full = (state == MODE_RUN) || (state == MODE_WAKE) || (state == MODE_RESET);
  assign rst_full    = (state == MODE_RESET) || (state == MODE_HWSTBY);
  assign asleep      = (state == MODE_SUBSLEEP);

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    assign mod_clk_en[m] = clocks_full || (asleep && KEEP_MASK[m]);
    assign mod_rst[m]    = rst_full || (asleep && VOLATILE_MASK[m]);
  end

  assign cpu_halt  = asleep || rst_full;
  assign exc_start = (state == MODE_WAKE);
endmodule

// File: rtl/subsleep_ctrl.sv
module subsleep_ctrl
  import subsleep_pkg::*;
#(
  parameter int                NUM_IRQ       = 6,
  parameter int                NUM_PER       = 8,
  parameter int                NUM_MOD       = 8,
  parameter logic [NUM_MOD-1:0] KEEP_MASK     = 8'h03,
  parameter logic [NUM_MOD-1:0] VOLATILE_MASK = 8'hF0
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               sleep_strobe,
  input  logic               sel_sw_standby,
  input  logic               sel_low_speed,
  input  logic               sel_wdog_prescale,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_PER-1:0] per_req,
  input  logic [NUM_PER-1:0] per_en,
  input  logic               cpu_mask,
  input  logic               nmi_req,
  input  logic               reset_pin_n,
  input  logic               standby_pin_n,
  output logic               cpu_halt,
  output logic [NUM_MOD-1:0] mod_clk_en,
  output logic [NUM_MOD-1:0] mod_rst,
  output logic [2:0]         mode,
  output logic               exc_start,
  output logic               sleep_nack
);
  pmode_e             state;
  logic               standby_force;
  logic               reset_force;
  logic               enter_req;
  logic               reject_req;
  logic               wake_hit;
  logic [NUM_IRQ-1:0] irq_hit;
  logic [NUM_PER-1:0] per_hit;

  assign standby_force = !standby_pin_n;
  assign reset_force   = standby_pin_n && !reset_pin_n;

  subsleep_entry_qual u_entry (
    .sleep_strobe      (sleep_strobe),
    .sel_sw_standby    (sel_sw_standby),
    .sel_low_speed     (sel_low_speed),
    .sel_wdog_prescale (sel_wdog_prescale),
    .in_run            (state == MODE_RUN),
    .pins_quiet        (standby_pin_n && reset_pin_n),
    .enter_req         (enter_req),
    .reject_req        (reject_req)
  );

  subsleep_wake_qual #(.NUM_IRQ(NUM_IRQ), .NUM_PER(NUM_PER)) u_wake (
    .nmi_req  (nmi_req),
    .irq_req  (irq_req),
    .irq_en   (irq_en),
    .per_req  (per_req),
    .per_en   (per_en),
    .cpu_mask (cpu_mask),
    .irq_hit  (irq_hit),
    .per_hit  (per_hit),
    .wake_hit (wake_hit)
  );

  subsleep_mode_fsm u_fsm (
    .clk           (clk),
    .por_n         (por_n),
    .enter_req     (enter_req),
    .reject_req    (reject_req),
    .wake_hit      (wake_hit),
    .standby_force (standby_force),
    .reset_force   (reset_force),
    .state         (state),
    .sleep_nack    (sleep_nack)
  );

  subsleep_gate #(
    .NUM_MOD       (NUM_MOD),
    .KEEP_MASK     (KEEP_MASK),
    .VOLATILE_MASK (VOLATILE_MASK)
  ) u_gate (
    .state      (state),
    .mod_clk_en (mod_clk_en),
    .mod_rst    (mod_rst),
    .cpu_halt   (cpu_halt),
    .exc_start  (exc_start)
  );

  assign mode = state;
endmodule

// File: rtl/subsleep_checker.sv
module subsleep_checker #(
  parameter int                NUM_MOD       = 8,
  parameter logic [NUM_MOD-1:0] KEEP_MASK     = 8'h03,
  parameter logic [NUM_MOD-1:0] VOLATILE_MASK = 8'hF0
) (
  input logic               clk,
  input logic               por_n,
  input logic               standby_pin_n,
  input logic               reset_pin_n,
  input logic [2:0]         mode,
  input logic               cpu_halt,
  input logic [NUM_MOD-1:0] mod_clk_en,
  input logic [NUM_MOD-1:0] mod_rst,
  input logic               exc_start,
  input logic               sleep_nack,
  input logic               enter_req,
  input logic               reject_req,
  input logic               wake_hit
);
  assert_entry_R1: assert property (@(posedge clk) disable iff (!por_n)
    enter_req |=> mode == 3'd1);

  assert_refuse_R2: assert property (@(posedge clk) disable iff (!por_n)
    reject_req |=> (sleep_nack && mode == 3'd0));

  assert_sleep_clocks_R3: assert property (@(posedge clk) disable iff (!por_n)
    mode == 3'd1 |-> (cpu_halt && mod_clk_en == KEEP_MASK));

  assert_sleep_resets_R4: assert property (@(posedge clk) disable iff (!por_n)
    mode == 3'd1 |-> mod_rst == VOLATILE_MASK);

  assert_wake_pulse_R8: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 3'd1 && wake_hit && standby_pin_n && reset_pin_n) |=> (exc_start && !cpu_halt));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!por_n)
    exc_start |=> !exc_start);

  assert_standby_R9: assert property (@(posedge clk) disable iff (!por_n)
    !standby_pin_n |=> (mode == 3'd3 && mod_clk_en == '0 && cpu_halt && !sleep_nack));

  assert_reset_pin_R10: assert property (@(posedge clk) disable iff (!por_n)
    (standby_pin_n && !reset_pin_n) |=> (mode == 3'd4 && !exc_start && cpu_halt));

  assert_standby_exit_R11: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 3'd3 && standby_pin_n) |=> mode == 3'd4);
endmodule

bind subsleep_ctrl subsleep_checker #(
  .NUM_MOD       (NUM_MOD),
  .KEEP_MASK     (KEEP_MASK),
  .VOLATILE_MASK (VOLATILE_MASK)
) u_subsleep_checker (
  .clk           (clk),
  .por_n         (por_n),
  .standby_pin_n (standby_pin_n),
  .reset_pin_n   (reset_pin_n),
  .mode          (mode),
  .cpu_halt      (cpu_halt),
  .mod_clk_en    (mod_clk_en),
  .mod_rst       (mod_rst),
  .exc_start     (exc_start),
  .sleep_nack    (sleep_nack),
  .enter_req     (enter_req),
  .reject_req    (reject_req),
  .wake_hit      (wake_hit)
);

// File: tb/test_subsleep_ctrl.sv
module test_subsleep_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       por_n, sleep_strobe, sel_sw_standby, sel_low_speed, sel_wdog_prescale;
  logic [5:0] irq_req, irq_en;
  logic [7:0] per_req, per_en;
  logic       cpu_mask, nmi_req, reset_pin_n, standby_pin_n;
  logic       cpu_halt, exc_start, sleep_nack;
  logic [7:0] mod_clk_en, mod_rst;
  logic [2:0] mode;

  int checks = 0;
  int errors = 0;

  // expected gating patterns: two low watchdog bits kept, top four modules reset
  localparam int EXP_KEEP = (1 << 2) - 1;
  localparam int EXP_VOL  = 8'hFF ^ ((1 << 4) - 1);

  subsleep_ctrl i_subsleep_ctrl (
    .clk(clk), .por_n(por_n), .sleep_strobe(sleep_strobe),
    .sel_sw_standby(sel_sw_standby), .sel_low_speed(sel_low_speed),
    .sel_wdog_prescale(sel_wdog_prescale), .irq_req(irq_req), .irq_en(irq_en),
    .per_req(per_req), .per_en(per_en), .cpu_mask(cpu_mask), .nmi_req(nmi_req),
    .reset_pin_n(reset_pin_n), .standby_pin_n(standby_pin_n),
    .cpu_halt(cpu_halt), .mod_clk_en(mod_clk_en), .mod_rst(mod_rst),
    .mode(mode), .exc_start(exc_start), .sleep_nack(sleep_nack)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic quiet();
    sleep_strobe = 0; sel_sw_standby = 0; sel_low_speed = 0; sel_wdog_prescale = 0;
    irq_req = '0; irq_en = '0; per_req = '0; per_en = '0;
    cpu_mask = 0; nmi_req = 0; reset_pin_n = 1; standby_pin_n = 1;
  endtask

  task automatic go_sleep();
    @(negedge clk);
    {sel_sw_standby, sel_low_speed, sel_wdog_prescale} = 3'b011;
    sleep_strobe = 1;
    @(negedge clk);
    sleep_strobe = 0;
    chk("R1 enter", mode, 1);
  endtask

  task automatic nmi_back();
    nmi_req = 1;
    @(negedge clk);
    nmi_req = 0;
    chk("R7 nmi wake", mode, 2);
    @(negedge clk);
    chk("R8 back to run", mode, 0);
  endtask

  task automatic settle(input bit woke);
    if (woke) begin
      @(negedge clk);
      chk("R8 run after wake", mode, 0);
    end else begin
      nmi_back();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    quiet();
    por_n = 0;
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    chk("R12 mode", mode, 0);
    chk("R12 halt", cpu_halt, 0);
    chk("R12 exc", exc_start, 0);
    chk("R12 nack", sleep_nack, 0);
    chk("R12 clk_en", mod_clk_en, 255);
    chk("R4 run rst", mod_rst, 0);

    // R1/R2 sweep over all control-bit settings
    for (int c = 0; c < 8; c++) begin
      bit ok;
      ok = (c == 3);
      {sel_sw_standby, sel_low_speed, sel_wdog_prescale} = c[2:0];
      sleep_strobe = 1;
      @(negedge clk);
      sleep_strobe = 0;
      chk(ok ? "R1 entry mode" : "R2 refused mode", mode, ok ? 1 : 0);
      chk("R2 nack", sleep_nack, ok ? 0 : 1);
      if (ok) begin
        chk("R3 halt", cpu_halt, 1);
        chk("R3 clk_en", mod_clk_en, EXP_KEEP);
        chk("R4 sleep rst", mod_rst, EXP_VOL);
        @(negedge clk);
        chk("R2 nack clears", sleep_nack, 0);
        nmi_back();
        chk("R3 run clocks", mod_clk_en, 255);
        chk("R3 run halt", cpu_halt, 0);
      end else begin
        @(negedge clk);
        chk("R2 nack one cycle", sleep_nack, 0);
        chk("R2 still run", mode, 0);
      end
    end

    // R5 external request lines, enable on or off
    for (int i = 0; i < 6; i++) begin
      for (int e = 0; e < 2; e++) begin
        go_sleep();
        irq_req = 6'(1 << i);
        irq_en  = e ? 6'(1 << i) : ~6'(1 << i);
        @(negedge clk);
        irq_req = '0;
        chk("R5 irq wake", mode, e ? 2 : 1);
        if (e) chk("R8 exc pulse", exc_start, 1);
        else   chk("R5 no exc", exc_start, 0);
        settle(e != 0);
      end
    end
    irq_en = '0;

    // R6 peripheral lines with enable and CPU mask
    for (int p = 0; p < 8; p++) begin
      for (int v = 0; v < 4; v++) begin
        bit e, m, w;
        e = v[0]; m = v[1]; w = e && !m;
        go_sleep();
        per_req = 8'(1 << p);
        per_en  = e ? 8'(1 << p) : ~8'(1 << p);
        cpu_mask = m;
        @(negedge clk);
        per_req = '0;
        chk("R6 per wake", mode, w ? 2 : 1);
        chk("R8 halt in wake", cpu_halt, w ? 0 : 1);
        settle(w);
        @(negedge clk);
        chk("R8 pulse gone", exc_start, 0);
      end
    end
    per_en = '0; cpu_mask = 0;

    // R7 NMI with everything masked
    go_sleep();
    cpu_mask = 1;
    nmi_back();
    cpu_mask = 0;

    // R10 wake and reset pin together
    go_sleep();
    nmi_req = 1; reset_pin_n = 0;
    @(negedge clk);
    nmi_req = 0;
    chk("R10 reset mode", mode, 4);
    chk("R10 no exc", exc_start, 0);
    chk("R10 halt", cpu_halt, 1);
    chk("R10 rst all", mod_rst, 255);
    @(negedge clk);
    chk("R10 held", mode, 4);
    reset_pin_n = 1;
    @(negedge clk);
    chk("R10 release", mode, 0);

    // R9 wake, reset and standby together
    go_sleep();
    nmi_req = 1; reset_pin_n = 0; standby_pin_n = 0;
    @(negedge clk);
    nmi_req = 0; reset_pin_n = 1;
    chk("R9 standby mode", mode, 3);
    chk("R9 clocks off", mod_clk_en, 0);
    chk("R9 rst all", mod_rst, 255);
    chk("R9 halt", cpu_halt, 1);
    chk("R9 no exc", exc_start, 0);
    standby_pin_n = 1;
    @(negedge clk);
    chk("R11 via reset", mode, 4);
    @(negedge clk);
    chk("R11 to run", mode, 0);

    // R9 sleep request together with standby in run mode
    {sel_sw_standby, sel_low_speed, sel_wdog_prescale} = 3'b100;
    sleep_strobe = 1; standby_pin_n = 0;
    @(negedge clk);
    sleep_strobe = 0;
    chk("R9 standby over sleep", mode, 3);
    chk("R9 no nack", sleep_nack, 0);
    standby_pin_n = 1;
    @(negedge clk);
    chk("R11 exit reset", mode, 4);
    @(negedge clk);
    chk("R11 exit run", mode, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule